// File: doc/BRIEF.md
# Single-Byte I2C Target with Strap-Selected Address

This block is an I2C target that is oversampled by a fast system clock. It supports Standard-mode and Fast-mode buses. Both bus lines pass through a synchronizer and a glitch filter before they reach the protocol logic. The target never drives SCL. It pulls SDA low through an open-drain enable, and the bus pull-up provides the high level.

The 7-bit target address has five fixed upper bits, `00111`. The two strap inputs supply the two low bits, so the address byte on the wire is `0 0 1 1 1 s1 s0 RW`, where `s1 = strap_addr[1]` and `s0 = strap_addr[0]`.

Every transaction carries exactly one data byte:
- **Write** (RW = 0): the target acknowledges the byte and hands it to the core with a one-cycle strobe.
- **Read** (RW = 1): the target sends the byte on `rd_data`, sampled at the end of the address acknowledge.
- Any byte after the first one in a transaction gets no acknowledge and has no effect.

Top module: `strap_i2c_target`

## Requirements
- R1: After reset the target releases SDA (`sda_oe` = 0) and `wr_strobe` is low.
- R2: An address byte whose upper seven bits equal `{5'b00111, strap_addr[1], strap_addr[0]}` is acknowledged: SDA is held low during the ninth SCL pulse.
- R3: An address byte that does not match gets no acknowledge. The target then leaves SDA released and raises no strobe until the next START.
- R4: On a write, the single data byte (MSB first) is acknowledged. `wr_data` then holds that byte while `wr_strobe` pulses high for exactly one clock, and the acknowledge drive starts in that same clock.
- R5: Bytes after the first data byte of a transaction get no acknowledge. A write raises no strobe for them, and a read leaves SDA released for them (the host reads 0xFF).
- R6: On a read, the target sends `rd_data` MSB first, and its SDA drive changes only while SCL is low.
- R7: After the eighth bit of a read byte, the target releases SDA, so the host's ninth-clock acknowledge slot sees the line high unless the host drives it.
- R8: A repeated START restarts address reception in any state. A partial byte in progress is discarded and raises no strobe.
- R9: A STOP (SDA rising while SCL is high) releases SDA and returns the target to idle. Clock pulses that arrive before the next START are ignored.
- R10: A pulse on SCL shorter than `FILTER_CYCLES` system clocks is not seen as a clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System oversampling clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus SCL level |
| sda_i | input | 1 | Bus SDA level |
| sda_oe | output | 1 | 1 = pull SDA low, 0 = release |
| strap_addr | input | 2 | Low two address bits from strap pins |
| rd_data | input | 8 | Byte returned on a read transaction |
| wr_data | output | 8 | Byte received on a write transaction |
| wr_strobe | output | 1 | One-cycle pulse when `wr_data` is updated |

## Verification
Wrong internal state shows up at the ports within one byte time.
- A bit counter that is off by one moves the acknowledge slot. The host then sees a missing acknowledge on a matching address, or a spurious low on a non-matching one, at the ninth clock of that byte.
- A state machine that fails to fall back to idle after a mismatch or a STOP shows up as a later acknowledge, strobe or SDA drive when no transfer is open.
- A shift-register error shows as a wrong `wr_data` at the strobe, or a wrong bit read back by the host.
- A filter that passes short pulses adds an extra clock, which corrupts the address and suppresses the acknowledge.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;

    localparam int BYTE_W    = 8;
    localparam int ADDR_W    = 7;
    localparam int STRAP_W   = 2;
    localparam int ADDR_HI_W = ADDR_W - STRAP_W;
    localparam int CNT_W     = $clog2(BYTE_W + 1);
    localparam int LINE_CNT  = 2;
    localparam int LINE_SCL  = 0;
    localparam int LINE_SDA  = 1;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_WDATA,
        ST_WACK,
        ST_RDATA,
        ST_SKIP
    } tgt_state_e;

    typedef struct packed {
        logic start;
        logic stop;
        logic scl_rise;
        logic scl_fall;
        logic sda;
    } bus_evt_t;

    function automatic logic addr_hit(
        input logic [BYTE_W-1:0]    first_byte,
        input logic [ADDR_HI_W-1:0] fixed_hi,
        input logic [STRAP_W-1:0]   strap
    );
        return first_byte[BYTE_W-1:1] == {fixed_hi, strap};
    endfunction

endpackage

// File: rtl/i2c_glitch_filter.sv
module i2c_glitch_filter #(
    parameter int SYNC_STAGES = 2,
    parameter int HOLD_CYCLES = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic raw,
    output logic clean
);
    localparam int CW = $clog2(HOLD_CYCLES) + 1;

    logic [SYNC_STAGES-1:0] sync_q;
    logic [CW-1:0]          run_cnt;
    logic                   synced;

    assign synced = sync_q[SYNC_STAGES-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q  <= '1;
            clean   <= 1'b1;
            run_cnt <= '0;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], raw};
            if (synced != clean) begin
                if (run_cnt == CW'(HOLD_CYCLES - 1)) begin
                    clean   <= synced;
                    run_cnt <= '0;
                end else begin
                    run_cnt <= run_cnt + CW'(1);
                end
            end else begin
                run_cnt <= '0;
            end
        end
    end
endmodule

// File: rtl/i2c_bus_events.sv
module i2c_bus_events
    import i2c_tgt_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_f,
    input  logic     sda_f,
    output bus_evt_t evt
);
    logic scl_q;
    logic sda_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_f;
            sda_q <= sda_f;
        end
    end

    always_comb begin
        evt.start    = scl_f & scl_q & sda_q & ~sda_f;
        evt.stop     = scl_f & scl_q & ~sda_q & sda_f;
        evt.scl_rise = scl_f & ~scl_q;
        evt.scl_fall = ~scl_f & scl_q;
        evt.sda      = sda_f;
    end
endmodule

// File: rtl/i2c_txn_fsm.sv
module i2c_txn_fsm
    import i2c_tgt_pkg::*;
#(
    parameter logic [ADDR_HI_W-1:0] ADDR_HI = 5'b00111
) (
    input  logic               clk,
    input  logic               rst,
    input  bus_evt_t           evt,
    input  logic [STRAP_W-1:0] strap,
    input  logic [BYTE_W-1:0]  rd_data,
    output logic               sda_oe,
    output logic [BYTE_W-1:0]  wr_data,
    output logic               wr_strobe,
    output logic               idle
);
    tgt_state_e        state;
    logic [BYTE_W-1:0] shreg;
    logic [CNT_W-1:0]  bitcnt;
    logic              rw;
    logic              byte_done;

    assign byte_done = (bitcnt == CNT_W'(BYTE_W));
    assign idle      = (state == ST_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            shreg     <= '0;
            bitcnt    <= '0;
            rw        <= 1'b0;
            sda_oe    <= 1'b0;
            wr_data   <= '0;
            wr_strobe <= 1'b0;
        end else begin
            wr_strobe <= 1'b0;
            if (evt.start) begin
                state  <= ST_ADDR;
                bitcnt <= '0;
                sda_oe <= 1'b0;
            end else if (evt.stop) begin
                state  <= ST_IDLE;
                sda_oe <= 1'b0;
            end else begin
                unique case (state)
                    ST_ADDR: begin
                        if (evt.scl_rise && !byte_done) begin
                            shreg  <= {shreg[BYTE_W-2:0], evt.sda};
                            bitcnt <= bitcnt + CNT_W'(1);
                        end else if (evt.scl_fall && byte_done) begin
                            if (addr_hit(shreg, ADDR_HI, strap)) begin
                                sda_oe <= 1'b1;
                                rw     <= shreg[0];
                                state  <= ST_ADDR_ACK;
                            end else begin
                                state <= ST_IDLE;
                            end
                        end
                    end
                    ST_ADDR_ACK: begin
                        if (evt.scl_fall) begin
                            bitcnt <= '0;
                            if (rw) begin
                                shreg  <= rd_data;
                                sda_oe <= ~rd_data[BYTE_W-1];
                                state  <= ST_RDATA;
                            end else begin
                                sda_oe <= 1'b0;
                                state  <= ST_WDATA;
                            end
                        end
                    end
                    ST_WDATA: begin
                        if (evt.scl_rise && !byte_done) begin
                            shreg  <= {shreg[BYTE_W-2:0], evt.sda};
                            bitcnt <= bitcnt + CNT_W'(1);
                        end else if (evt.scl_fall && byte_done) begin
                            sda_oe    <= 1'b1;
                            wr_data   <= shreg;
                            wr_strobe <= 1'b1;
                            state     <= ST_WACK;
                        end
                    end
                    ST_WACK: begin
                        if (evt.scl_fall) begin
                            sda_oe <= 1'b0;
                            state  <= ST_SKIP;
                        end
                    end
                    ST_RDATA: begin
                        if (evt.scl_rise && !byte_done) begin
                            bitcnt <= bitcnt + CNT_W'(1);
                        end else if (evt.scl_fall) begin
                            if (byte_done) begin
                                sda_oe <= 1'b0;
                                state  <= ST_SKIP;
                            end else begin
                                shreg  <= {shreg[BYTE_W-2:0], 1'b0};
                                sda_oe <= ~shreg[BYTE_W-2];
                            end
                        end
                    end
                    default: begin
                        sda_oe <= 1'b0;
                    end
                endcase
            end
        end
    end
endmodule

// File: rtl/strap_i2c_target.sv
module strap_i2c_target
    import i2c_tgt_pkg::*;
#(
    parameter int                   SYNC_STAGES   = 2,
    parameter int                   FILTER_CYCLES = 4,
    parameter logic [ADDR_HI_W-1:0] ADDR_HI       = 5'b00111
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               scl_i,
    input  logic               sda_i,
    output logic               sda_oe,
    input  logic [STRAP_W-1:0] strap_addr,
    input  logic [BYTE_W-1:0]  rd_data,
    output logic [BYTE_W-1:0]  wr_data,
    output logic               wr_strobe
);
    logic [LINE_CNT-1:0] raw_lines;
    logic [LINE_CNT-1:0] clean_lines;
    logic                scl_f;
    logic                sda_f;
    logic                fsm_idle;
    bus_evt_t            evt;

    assign raw_lines[LINE_SCL] = scl_i;
    assign raw_lines[LINE_SDA] = sda_i;

    for (genvar g = 0; g < LINE_CNT; g++) begin : g_line
        i2c_glitch_filter #(
            .SYNC_STAGES(SYNC_STAGES),
            .HOLD_CYCLES(FILTER_CYCLES)
        ) u_filt (
            .clk  (clk),
            .rst  (rst),
            .raw  (raw_lines[g]),
            .clean(clean_lines[g])
        );
    end

    assign scl_f = clean_lines[LINE_SCL];
    assign sda_f = clean_lines[LINE_SDA];

    i2c_bus_events u_evt (
        .clk  (clk),
        .rst  (rst),
        .scl_f(scl_f),
        .sda_f(sda_f),
        .evt  (evt)
    );

    i2c_txn_fsm #(
        .ADDR_HI(ADDR_HI)
    ) u_fsm (
        .clk      (clk),
        .rst      (rst),
        .evt      (evt),
        .strap    (strap_addr),
        .rd_data  (rd_data),
        .sda_oe   (sda_oe),
        .wr_data  (wr_data),
        .wr_strobe(wr_strobe),
        .idle     (fsm_idle)
    );
endmodule

// File: rtl/strap_i2c_target_chk.sv
module strap_i2c_target_chk (
    input logic clk,
    input logic rst,
    input logic sda_oe,
    input logic wr_strobe,
    input logic scl_filt,
    input logic stop_evt,
    input logic in_idle
);
    AST_RESET_RELEASED: assert property (@(posedge clk) rst |=> (!sda_oe && !wr_strobe)); // R1
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst) in_idle |-> !sda_oe); // R3
    AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (rst) wr_strobe |=> !wr_strobe); // R4
    AST_STROBE_WITH_ACK: assert property (@(posedge clk) disable iff (rst) wr_strobe |-> sda_oe); // R4
    AST_DRIVE_SCL_LOW: assert property (@(posedge clk) disable iff (rst) !$stable(sda_oe) |-> !scl_filt); // R6
    AST_STOP_RELEASE: assert property (@(posedge clk) disable iff (rst) stop_evt |=> !sda_oe); // R9
endmodule

bind strap_i2c_target strap_i2c_target_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .sda_oe   (sda_oe),
    .wr_strobe(wr_strobe),
    .scl_filt (scl_f),
    .stop_evt (evt.stop),
    .in_idle  (fsm_idle)
);

// File: tb/test_strap_i2c_target.sv
`timescale 1ns/1ps
module test_strap_i2c_target;
    localparam int Q = 12;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       host_scl = 1'b1;
    logic       host_sda = 1'b1;
    logic       sda_oe;
    logic       sda_line;
    logic [1:0] strap = 2'b10;
    logic [7:0] rd_data = 8'h00;
    logic [7:0] wr_data;
    logic       wr_strobe;

    int errors = 0;
    int checks = 0;
    int strobes = 0;
    int drive_violations = 0;
    logic [7:0] last_wr = 8'h00;
    logic prev_oe = 1'b0;

    always #2.5 clk = ~clk;

    assign sda_line = host_sda & ~sda_oe;

    strap_i2c_target i_strap_i2c_target (
        .clk       (clk),
        .rst       (rst),
        .scl_i     (host_scl),
        .sda_i     (sda_line),
        .sda_oe    (sda_oe),
        .strap_addr(strap),
        .rd_data   (rd_data),
        .wr_data   (wr_data),
        .wr_strobe (wr_strobe)
    );

    always @(negedge clk) begin
        if (wr_strobe) begin
            strobes++;
            last_wr = wr_data;
        end
        if (!rst && (sda_oe != prev_oe) && host_scl) drive_violations++;
        prev_oe = sda_oe;
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        host_sda = 1'b1; wait_n(Q);
        host_scl = 1'b1; wait_n(Q);
        host_sda = 1'b0; wait_n(Q);
        host_scl = 1'b0; wait_n(Q);
    endtask

    task automatic bus_stop();
        host_sda = 1'b0; wait_n(Q);
        host_scl = 1'b1; wait_n(Q);
        host_sda = 1'b1; wait_n(Q);
    endtask

    task automatic send_bit(input logic b);
        host_sda = b;    wait_n(Q);
        host_scl = 1'b1; wait_n(2 * Q);
        host_scl = 1'b0; wait_n(Q);
    endtask

    task automatic read_bit(output logic b);
        host_sda = 1'b1; wait_n(Q);
        host_scl = 1'b1; wait_n(Q);
        b = sda_line;    wait_n(Q);
        host_scl = 1'b0; wait_n(Q);
    endtask

    task automatic write_byte(input logic [7:0] v, output logic ack_n);
        for (int i = 7; i >= 0; i--) send_bit(v[i]);
        read_bit(ack_n);
    endtask

    task automatic read_byte(output logic [7:0] v);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            read_bit(b);
            v[i] = b;
        end
    endtask

    function automatic logic [7:0] addr_byte(input logic [1:0] s, input logic rw);
        return {5'b00111, s, rw};
    endfunction

    initial begin : watchdog
        wait_n(190000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : main
        logic ack_n;
        logic b;
        logic [7:0] got;
        int base;

        wait_n(5);
        // R1: reset state
        check("R1 sda_oe", int'(sda_oe), 0);
        check("R1 wr_strobe", int'(wr_strobe), 0);
        rst = 1'b0;
        wait_n(10);
        check("R1 idle after reset", int'(sda_oe), 0);

        // R2/R3: address sweep with strap = 2'b10, matches 7'h1E only
        strap = 2'b10;
        base = strobes;
        for (int a = 0; a < 128; a++) begin
            bus_start();
            write_byte({a[6:0], 1'b0}, ack_n);
            check((a == 'h1E) ? "R2 address ack" : "R3 address nack",
                  int'(ack_n), (a == 'h1E) ? 0 : 1);
            bus_stop();
        end
        check("R3 no strobe in address sweep", strobes - base, 0);

        // R2: each strap value selects its own address
        for (int s = 0; s < 4; s++) begin
            strap = s[1:0];
            bus_start();
            write_byte(addr_byte(s[1:0], 1'b0), ack_n);
            check("R2 strap match", int'(ack_n), 0);
            bus_stop();
            bus_start();
            write_byte(addr_byte(~s[1:0], 1'b0), ack_n);
            check("R2 strap other", int'(ack_n), 1);
            // R3: after mismatch, data clocks get no ack and no drive
            write_byte(8'h00, ack_n);
            check("R3 silent after mismatch", int'(ack_n), 1);
            bus_stop();
        end

        // R4: writes of several patterns
        strap = 2'b01;
        for (int k = 0; k < 6; k++) begin
            logic [7:0] v;
            v = 8'(k * 8'h4B + 8'h11);
            base = strobes;
            bus_start();
            write_byte(addr_byte(2'b01, 1'b0), ack_n);
            check("R4 addr ack", int'(ack_n), 0);
            write_byte(v, ack_n);
            check("R4 data ack", int'(ack_n), 0);
            bus_stop();
            check("R4 one strobe", strobes - base, 1);
            check("R4 wr_data", int'(last_wr), int'(v));
        end

        // R5: extra write byte ignored
        base = strobes;
        bus_start();
        write_byte(addr_byte(2'b01, 1'b0), ack_n);
        write_byte(8'hC3, ack_n);
        check("R5 first data ack", int'(ack_n), 0);
        write_byte(8'h5E, ack_n);
        check("R5 extra byte nack", int'(ack_n), 1);
        bus_stop();
        check("R5 strobe count", strobes - base, 1);
        check("R5 wr_data kept", int'(last_wr), 'hC3);

        // R6/R7/R5: reads
        for (int k = 0; k < 5; k++) begin
            rd_data = 8'(8'h81 ^ (k * 8'h37));
            bus_start();
            write_byte(addr_byte(2'b01, 1'b1), ack_n);
            check("R6 read addr ack", int'(ack_n), 0);
            read_byte(got);
            check("R6 read data", int'(got), int'(rd_data));
            read_bit(b);
            check("R7 released in ack slot", int'(b), 1);
            read_byte(got);
            check("R5 extra read released", int'(got), 'hFF);
            bus_stop();
        end

        // R8: repeated START after mismatch and mid-byte
        base = strobes;
        bus_start();
        write_byte(addr_byte(2'b10, 1'b0), ack_n);
        check("R8 mismatch nack", int'(ack_n), 1);
        bus_start();
        write_byte(addr_byte(2'b01, 1'b0), ack_n);
        check("R8 restart ack", int'(ack_n), 0);
        send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
        bus_start();
        write_byte(addr_byte(2'b01, 1'b0), ack_n);
        check("R8 second restart ack", int'(ack_n), 0);
        write_byte(8'h96, ack_n);
        check("R8 data ack", int'(ack_n), 0);
        bus_stop();
        check("R8 single strobe", strobes - base, 1);
        check("R8 wr_data", int'(last_wr), 'h96);

        // R9: after STOP, clocks without START are ignored
        check("R9 released after stop", int'(sda_oe), 0);
        base = strobes;
        host_scl = 1'b0; wait_n(Q);
        write_byte(addr_byte(2'b01, 1'b0), ack_n);
        check("R9 no ack without start", int'(ack_n), 1);
        write_byte(8'h42, ack_n);
        check("R9 no data ack", int'(ack_n), 1);
        check("R9 no strobe", strobes - base, 0);
        host_sda = 1'b0; wait_n(Q);
        host_scl = 1'b1; wait_n(Q);
        host_sda = 1'b1; wait_n(Q);

        // R10: short SCL glitch during address
        bus_start();
        for (int i = 7; i >= 0; i--) begin
            send_bit(addr_byte(2'b01, 1'b0) >> i);
            if (i == 5) begin
                host_scl = 1'b1; wait_n(2);
                host_scl = 1'b0; wait_n(Q);
            end
        end
        read_bit(ack_n);
        check("R10 glitch filtered", int'(ack_n), 0);
        bus_stop();

        check("R6 drive changes only with SCL low", drive_violations, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule